// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a 32-bit host reach a small 8-bit register subsystem that cannot be addressed directly. The host loads a command word naming the subsystem register, the transfer direction and byte enables, then moves data through a data register. While the subsystem transfer runs, a busy flag in the command word stays high, and software polls it before its next access. A read begins as soon as a command word with the read direction is stored. A write begins when the low data word is stored after a command word with the write direction.

The bridge also owns two interrupt sources and combines them into one request line. One source is a level from the subsystem. The other marks the end of each transfer. Each source has an enable bit, and each flag is cleared by writing a one to it. The transfer time is a parameter, `LATENCY`, which fixes how many cycles busy stays high.

Top module: `ireg_bridge`

## Requirements
- R1: After reset, the command, low data, high data, enable and flag words all read zero, busy is 0 and `irq_o` is 0.
- R2: Word offset 0x00 returns the parameter `ID_VALUE`, and writes to that offset have no effect.
- R3: The command word at offset 0x04 reads back with busy at bit 31, size at bit 25, direction at bit 24 (1 = read from the subsystem), upper-word byte enables at bits 23:20, lower-word byte enables at bits 19:16 (bit 16 = least significant byte) and the subsystem address at bits 7:0. All other bits read 0.
- R4: A command write with bit 24 set starts a read. Busy is 1 for exactly `LATENCY` cycles from the cycle after that write. The subsystem read strobe fires once, in the last busy cycle. Afterwards the low data word at offset 0x08 holds the subsystem byte in bits 7:0, with zeros above.
- R5: A write to the low data word that follows a command word with bit 24 clear starts a write, which also keeps busy high for `LATENCY` cycles. In the last busy cycle, data bits 7:0 go to the addressed subsystem register, but only if command bit 16 is set. With bit 16 clear, the transfer still runs and the register keeps its value.
- R6: A low data write that was not preceded by a write-direction command word only stores the data. It starts no transfer.
- R7: While busy is 1, writes to the command, low data and high data words are ignored.
- R8: The high data word at offset 0x0C stores and returns all 32 bits written while idle.
- R9: The enable word at offset 0x10 keeps bits 1:0, and all its other bits read 0.
- R10: In the flag word at offset 0x14, bit 1 is set in any cycle where `sub_irq` is high, and bit 0 is set when a transfer completes. Writing 1 to a bit clears it. A set in the same cycle as a clear wins.
- R11: `irq_o` is high exactly when some flag bit and its enable bit are both 1.
- R12: Unmapped word offsets and addresses with bits 1:0 not zero read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | HOST_AW | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational from address) |
| sub_addr | output | SUB_AW | Subsystem register address |
| sub_wdata | output | SUB_DW | Subsystem write data |
| sub_we | output | 1 | Subsystem write strobe, one cycle |
| sub_re | output | 1 | Subsystem read strobe, one cycle; data sampled in the same cycle |
| sub_rdata | input | SUB_DW | Subsystem read data |
| sub_irq | input | 1 | Subsystem event level |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Some properties are checked on every cycle: the length of each busy window against `LATENCY`, that subsystem strobes appear only inside a busy window, that the stored command stays unchanged when written during a transfer, that a completed read leaves zeros above the byte, and that a subsystem event raises its flag. Other behaviour needs the bench's scenarios. These are the data round trip through the subsystem, which is compared against a shadow copy kept in the bench. They also cover write suppression when the low byte enable is clear, the start rule that depends on a previously stored write command, write-one-to-clear with a set in the same cycle, and the register layout seen on readback.

// File: rtl/ireg_bridge_pkg.sv
package ireg_bridge_pkg;
   // word slots decoded from host address bits 4:2
   localparam logic [2:0] SLOT_ID    = 3'd0;
   localparam logic [2:0] SLOT_CMD   = 3'd1;
   localparam logic [2:0] SLOT_LDATA = 3'd2;
   localparam logic [2:0] SLOT_UDATA = 3'd3;
   localparam logic [2:0] SLOT_IEN   = 3'd4;
   localparam logic [2:0] SLOT_IFLG  = 3'd5;

   // command word bit positions
   localparam int CMD_BUSY_BIT = 31;
   localparam int CMD_SIZE_BIT = 25;
   localparam int CMD_DIR_BIT  = 24;
   localparam int CMD_BEU_LSB  = 20;
   localparam int CMD_BEL_LSB  = 16;

   // interrupt source indices
   localparam int NUM_SRC  = 2;
   localparam int SRC_XFER = 0;
   localparam int SRC_SUB  = 1;

   typedef struct packed {
      logic       size;
      logic       dir;
      logic [3:0] be_hi;
      logic [3:0] be_lo;
   } cmd_t;
endpackage

// File: rtl/ireg_seq.sv
module ireg_seq #(
   parameter int LATENCY = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);
   logic busy_q;

   generate
      if (LATENCY < 1) begin : g_bad_latency
         $error("ireg_seq: LATENCY must be at least 1");
      end

      if (LATENCY == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy_q <= 1'b0;
            else        busy_q <= start_i;
         end
         assign done_o = busy_q;
      end else begin : g_count
         localparam int CW = $clog2(LATENCY);
         logic [CW-1:0] left_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy_q <= 1'b0;
               left_q <= '0;
            end else if (start_i) begin
               busy_q <= 1'b1;
               left_q <= CW'(LATENCY - 1);
            end else if (busy_q) begin
               if (left_q == '0) busy_q <= 1'b0;
               else              left_q <= left_q - 1'b1;
            end
         end
         assign done_o = busy_q && (left_q == '0);
      end
   endgenerate

   assign busy_o = busy_q;
endmodule

// File: rtl/ireg_irq_agg.sv
module ireg_irq_agg #(
   parameter int NSRC = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_i,
   input  logic [NSRC-1:0] clr_i,
   input  logic [NSRC-1:0] en_i,
   output logic [NSRC-1:0] flag_o,
   output logic            irq_o
);
   generate
      if (NSRC < 1) begin : g_bad_nsrc
         $error("ireg_irq_agg: NSRC must be at least 1");
      end
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_o[i] <= 1'b0;
            else if (set_i[i]) flag_o[i] <= 1'b1;
            else if (clr_i[i]) flag_o[i] <= 1'b0;
         end
      end
   endgenerate

   assign irq_o = |(flag_o & en_i);
endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge
   import ireg_bridge_pkg::*;
#(
   parameter int          HOST_AW  = 5,
   parameter int          SUB_AW   = 8,
   parameter int          SUB_DW   = 8,
   parameter int          LATENCY  = 4,
   parameter logic [31:0] ID_VALUE = 32'h4952_0100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic [SUB_AW-1:0] sub_addr,
   output logic [SUB_DW-1:0] sub_wdata,
   output logic              sub_we,
   output logic              sub_re,
   input  logic [SUB_DW-1:0] sub_rdata,
   input  logic              sub_irq,
   output logic              irq_o
);
   localparam int PAD_W = 32 - SUB_DW;

   generate
      if (HOST_AW < 5) begin : g_bad_haw
         $error("ireg_bridge: HOST_AW must cover six word slots");
      end
      if (SUB_AW < 1 || SUB_AW > 16) begin : g_bad_saw
         $error("ireg_bridge: SUB_AW must lie in 1..16");
      end
      if (SUB_DW < 1 || SUB_DW > 8) begin : g_bad_sdw
         $error("ireg_bridge: SUB_DW must lie in 1..8");
      end
   endgenerate

   // decode
   logic       hit;
   logic [2:0] slot;
   assign hit  = ((host_addr >> 5) == '0) && (host_addr[1:0] == 2'b00);
   assign slot = host_addr[4:2];

   logic busy, done;
   logic wr_cmd, wr_ldata, wr_udata, wr_ien, wr_iflg;
   assign wr_cmd   = host_we && hit && slot == SLOT_CMD   && !busy;
   assign wr_ldata = host_we && hit && slot == SLOT_LDATA && !busy;
   assign wr_udata = host_we && hit && slot == SLOT_UDATA && !busy;
   assign wr_ien   = host_we && hit && slot == SLOT_IEN;
   assign wr_iflg  = host_we && hit && slot == SLOT_IFLG;

   // stored command
   cmd_t              cmd_q;
   logic [SUB_AW-1:0] addr_q;
   logic              armed_q;
   logic [31:0]       ldata_q, udata_q;
   logic [NUM_SRC-1:0] ien_q, flag_q;

   logic start_rd, start_wr;
   assign start_rd = wr_cmd && host_wdata[CMD_DIR_BIT];
   assign start_wr = wr_ldata && armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         addr_q  <= '0;
         armed_q <= 1'b0;
      end else if (wr_cmd) begin
         cmd_q.size  <= host_wdata[CMD_SIZE_BIT];
         cmd_q.dir   <= host_wdata[CMD_DIR_BIT];
         cmd_q.be_hi <= host_wdata[CMD_BEU_LSB +: 4];
         cmd_q.be_lo <= host_wdata[CMD_BEL_LSB +: 4];
         addr_q      <= host_wdata[SUB_AW-1:0];
         armed_q     <= !host_wdata[CMD_DIR_BIT];
      end else if (start_wr) begin
         armed_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ldata_q <= '0;
         udata_q <= '0;
         ien_q   <= '0;
      end else begin
         if (wr_ldata)               ldata_q <= host_wdata;
         else if (done && cmd_q.dir) ldata_q <= {{PAD_W{1'b0}}, sub_rdata};
         if (wr_udata) udata_q <= host_wdata;
         if (wr_ien)   ien_q   <= host_wdata[NUM_SRC-1:0];
      end
   end

   ireg_seq #(.LATENCY(LATENCY)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_rd || start_wr),
      .busy_o (busy),
      .done_o (done)
   );

   logic [NUM_SRC-1:0] src_set, src_clr;
   always_comb begin
      src_set           = '0;
      src_set[SRC_SUB]  = sub_irq;
      src_set[SRC_XFER] = done;
      src_clr           = wr_iflg ? host_wdata[NUM_SRC-1:0] : '0;
   end

   ireg_irq_agg #(.NSRC(NUM_SRC)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (src_set),
      .clr_i (src_clr),
      .en_i  (ien_q),
      .flag_o(flag_q),
      .irq_o (irq_o)
   );

   // subsystem side
   assign sub_addr  = addr_q;
   assign sub_wdata = ldata_q[SUB_DW-1:0];
   assign sub_we    = done && !cmd_q.dir && cmd_q.be_lo[0];
   assign sub_re    = done && cmd_q.dir;

   // host read mux
   always_comb begin
      host_rdata = '0;
      if (hit) begin
         case (slot)
            SLOT_ID:    host_rdata = ID_VALUE;
            SLOT_CMD: begin
               host_rdata[CMD_BUSY_BIT]       = busy;
               host_rdata[CMD_SIZE_BIT]       = cmd_q.size;
               host_rdata[CMD_DIR_BIT]        = cmd_q.dir;
               host_rdata[CMD_BEU_LSB +: 4]   = cmd_q.be_hi;
               host_rdata[CMD_BEL_LSB +: 4]   = cmd_q.be_lo;
               host_rdata[SUB_AW-1:0]         = addr_q;
            end
            SLOT_LDATA: host_rdata = ldata_q;
            SLOT_UDATA: host_rdata = udata_q;
            SLOT_IEN:   host_rdata[NUM_SRC-1:0] = ien_q;
            SLOT_IFLG:  host_rdata[NUM_SRC-1:0] = flag_q;
            default:    host_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/ireg_bridge_chk.sv
module ireg_bridge_chk #(
   parameter int LATENCY = 4,
   parameter int HOST_AW = 5,
   parameter int SUB_AW  = 8,
   parameter int SUB_DW  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               busy,
   input logic               sub_we,
   input logic               sub_re,
   input logic               sub_irq,
   input logic [1:0]         flag,
   input logic               host_we,
   input logic [HOST_AW-1:0] host_addr,
   input logic [SUB_AW+9:0]  cmd_state,
   input logic [31:0]        ldata
);
   int unsigned run_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_cnt <= 0;
      else if (busy) run_cnt <= run_cnt + 1;
      else           run_cnt <= 0;
   end

   logic cmd_try;
   assign cmd_try = host_we && (host_addr == HOST_AW'(4));

   AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> run_cnt < LATENCY); // R4
   AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(run_cnt) == LATENCY - 1); // R4
   AST_STROBE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_we || sub_re) |-> busy); // R5
   AST_READ_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      sub_re |=> (ldata >> SUB_DW) == 32'd0); // R4
   AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_try) |=> $stable(cmd_state)); // R7
   AST_SUB_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      sub_irq |=> flag[1]); // R10
endmodule

bind ireg_bridge ireg_bridge_chk #(
   .LATENCY(LATENCY), .HOST_AW(HOST_AW), .SUB_AW(SUB_AW), .SUB_DW(SUB_DW)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .sub_we   (sub_we),
   .sub_re   (sub_re),
   .sub_irq  (sub_irq),
   .flag     (flag_q),
   .host_we  (host_we),
   .host_addr(host_addr),
   .cmd_state({cmd_q, addr_q}),
   .ldata    (ldata_q)
);

// File: tb/ireg_bridge_test.sv
module ireg_bridge_test;
   localparam int CLK_PERIOD = 10;
   localparam int LAT = 4;
   localparam logic [31:0] IDV = 32'h4952_0100;

   localparam logic [4:0] A_ID = 5'h00, A_CMD = 5'h04, A_LD = 5'h08,
                          A_UD = 5'h0C, A_IEN = 5'h10, A_FLG = 5'h14;

   logic clk = 0, rst_n = 0;
   logic host_we = 0;
   logic [4:0] host_addr = 0;
   logic [31:0] host_wdata = 0, host_rdata;
   logic [7:0] sub_addr, sub_wdata, sub_rdata;
   logic sub_we, sub_re, irq_o;
   logic sub_irq = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ireg_bridge #(.LATENCY(LAT), .ID_VALUE(IDV)) uut (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .sub_addr(sub_addr),
      .sub_wdata(sub_wdata), .sub_we(sub_we), .sub_re(sub_re),
      .sub_rdata(sub_rdata), .sub_irq(sub_irq), .irq_o(irq_o));

   // subsystem model and bench shadow
   logic [7:0] sub_mem [256];
   logic [7:0] shadow  [256];
   always @(posedge clk) if (sub_we) sub_mem[sub_addr] <= sub_wdata;
   assign sub_rdata = sub_mem[sub_addr];

   int errors = 0, checks = 0;

   function automatic logic [7:0] init_byte(input int i);
      return 8'((i * 37 + 5) & 8'hFF);
   endfunction

   function automatic logic [31:0] mk_cmd(input logic dir, input logic size,
         input logic [3:0] behi, input logic [3:0] belo, input logic [7:0] a);
      return {1'b0, 5'b0, size, dir, behi, belo, 8'h00, a};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // all tasks start and end at a falling edge
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      host_we = 1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_we = 0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      host_addr = a; #1; d = host_rdata;
   endtask

   task automatic wait_idle(output int n);
      logic [31:0] v;
      n = 0;
      for (int k = 0; k < 1000; k++) begin
         rd(A_CMD, v);
         if (!v[31]) break;
         n++;
         @(negedge clk);
      end
   endtask

   task automatic sub_read(input logic [7:0] a, input string req);
      int n; logic [31:0] v;
      wr(A_CMD, mk_cmd(1'b1, 1'b0, 4'h0, 4'h1, a));
      wait_idle(n);
      chk({req, " busy length"}, n, LAT);
      rd(A_LD, v);
      chk({req, " read data"}, v, {24'h0, shadow[a]});
   endtask

   task automatic sub_write(input logic [7:0] a, input logic [7:0] d, input logic be0);
      int n;
      wr(A_CMD, mk_cmd(1'b0, 1'b0, 4'h0, {3'b000, be0}, a));
      wr(A_LD, {24'h0, d});
      wait_idle(n);
      chk("R5 write busy length", n, LAT);
      if (be0) shadow[a] = d;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int n;
      void'($urandom(32'd1234));
      for (int i = 0; i < 256; i++) begin
         sub_mem[i] = init_byte(i);
         shadow[i]  = init_byte(i);
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      rd(A_CMD, v); chk("R1 cmd", v, 0);
      rd(A_LD, v);  chk("R1 ldata", v, 0);
      rd(A_UD, v);  chk("R1 udata", v, 0);
      rd(A_IEN, v); chk("R1 ien", v, 0);
      rd(A_FLG, v); chk("R1 flag", v, 0);
      chk("R1 irq", irq_o, 0);

      // R2 identity
      rd(A_ID, v); chk("R2 id", v, IDV);
      wr(A_ID, 32'h0); rd(A_ID, v); chk("R2 id after write", v, IDV);

      // R12 unmapped and unaligned
      wr(5'h18, 32'hFFFF_FFFF); rd(5'h18, v); chk("R12 unmapped", v, 0);
      wr(5'h0D, 32'h1111_1111); rd(5'h0D, v); chk("R12 unaligned read", v, 0);
      rd(A_UD, v); chk("R12 unaligned write ignored", v, 0);

      // R6 low data write with no write command pending
      wr(A_LD, 32'h0000_1234);
      rd(A_CMD, v); chk("R6 no busy", v[31], 0);
      rd(A_LD, v);  chk("R6 data stored", v, 32'h1234);

      // R3 command layout (write direction, no start until data written)
      wr(A_CMD, 32'h7C00_FF00 | mk_cmd(1'b0, 1'b1, 4'hA, 4'h5, 8'h3C));
      rd(A_CMD, v); chk("R3 cmd readback", v, mk_cmd(1'b0, 1'b1, 4'hA, 4'h5, 8'h3C));

      // R8 high data
      wr(A_UD, 32'hCAFE_F00D); rd(A_UD, v); chk("R8 udata", v, 32'hCAFE_F00D);

      // R9 enable mask
      wr(A_IEN, 32'hFFFF_FFFF); rd(A_IEN, v); chk("R9 ien bits", v, 32'h3);
      wr(A_IEN, 32'h0);

      // R4 read transfer
      sub_read(8'h10, "R4");
      // R10 transfer-complete flag, clear by writing one
      rd(A_FLG, v); chk("R10 xfer flag set", v, 32'h1);
      wr(A_FLG, 32'h1); rd(A_FLG, v); chk("R10 xfer flag cleared", v, 32'h0);

      // R10 subsystem event and set-over-clear
      sub_irq = 1; @(negedge clk); sub_irq = 0;
      rd(A_FLG, v); chk("R10 sub flag set", v, 32'h2);
      sub_irq = 1; wr(A_FLG, 32'h2); sub_irq = 0;
      rd(A_FLG, v); chk("R10 set wins over clear", v, 32'h2);

      // R11 interrupt combine
      wr(A_IEN, 32'h2); chk("R11 irq enabled", irq_o, 1);
      wr(A_IEN, 32'h1); chk("R11 irq masked", irq_o, 0);
      wr(A_FLG, 32'h3); wr(A_IEN, 32'h3); chk("R11 irq cleared", irq_o, 0);
      wr(A_IEN, 32'h0);

      // R5 write transfer with and without low byte enable
      sub_write(8'h20, 8'hA5, 1'b1);
      sub_read(8'h20, "R5 written byte");
      sub_write(8'h21, 8'h5A, 1'b0);
      sub_read(8'h21, "R5 suppressed write");

      // R7 writes during busy are ignored
      wr(A_UD, 32'h1357_9BDF);
      wr(A_CMD, mk_cmd(1'b1, 1'b0, 4'h0, 4'h1, 8'h30));
      wr(A_CMD, mk_cmd(1'b0, 1'b0, 4'h0, 4'h1, 8'h77));
      wr(A_UD, 32'hDEAD_BEEF);
      wr(A_LD, 32'h0000_FFFF);
      wait_idle(n);
      rd(A_CMD, v); chk("R7 cmd kept", v, mk_cmd(1'b1, 1'b0, 4'h0, 4'h1, 8'h30));
      rd(A_UD, v);  chk("R7 udata kept", v, 32'h1357_9BDF);
      rd(A_LD, v);  chk("R7 ldata from read", v, {24'h0, shadow[8'h30]});
      sub_read(8'h77, "R7 no stray write");

      // random mix of transfers
      for (int i = 0; i < 150; i++) begin
         logic [7:0] a, d;
         a = 8'($urandom);
         d = 8'($urandom);
         if ($urandom % 2) sub_write(a, d, 1'($urandom % 4 != 0));
         else              sub_read(a, "R4 random");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule